// File: doc/BRIEF.md
# Microcoded Memory Cycle Sequencer

This block drives external memory control pins from a 64-word pattern RAM. Each 32-bit microword sets the pin levels for one step. The sequencer walks through consecutive words until it finishes a word marked as final. Software controls it through two registers: a mode register, which holds a 2-bit opcode and a RAM address, and a 32-bit data register. Accesses that hit the sequencer's region are treated according to the opcode. They can store a word into the RAM, fetch a word back, start a stored pattern, or run one of the fixed entry patterns for a normal read or write.

A bus-monitor timeout during a running pattern sends the sequencer to a dedicated exception pattern, which releases the pins in a controlled order. The step outputs are registered. A word holds the pins for one cycle, longer when its wait bit is set and the external ready input is low, or when its loop bit asks for repeats. While the sequencer is busy, new accesses are dropped and register writes are stalled.

Top module: `pattern_seq`

## Requirements
- R1: With opcode 01 (mode register bits [7:6]), a write access stores the data register into the RAM at the mode register's address field (bits [5:0]). Busy is high for exactly one cycle, and the address field then increments by one, wrapping at 64.
- R2: With opcode 10, a read access copies the RAM word at the address field into the data register. The address field then increments by one.
- R3: With opcode 11, a write access starts a run at the address field. One cycle after the access is accepted, the pins show that word. Each later cycle shows the next consecutive word.
- R4: The sequence ends after the word whose LAST bit (word bit 7) is set. In the following cycle, busy is low and ctl_o returns to 4'hF.
- R5: In a software-started run, ta_o stays low whatever the transfer-acknowledge bit (word bit 5) holds, and bus_oe_o is high. In a normal-mode access, ta_o follows bit 5, and bus_oe_o is high only for a write.
- R6: With opcode 00, an access runs a fixed entry pattern. The entries are single read at 0, burst read at 8, single write at 24 and burst write at 32.
- R7: A word with its wait bit (bit 8) set holds the pins while ext_rdy_i is low. The sequencer advances on the first edge that sees ext_rdy_i high.
- R8: A word with its loop bit (bit 6) set is held for N+1 cycles, where N is the repeat field (bits [11:9]).
- R9: bmto_i high during a running pattern jumps to the exception pattern at address 60 on the next edge. That pattern then runs to its LAST word. bmto_i is ignored while the exception pattern runs.
- R10: Register writes are not taken while busy is high, and cfg_ready_o is low during that time. A write dropped before busy clears leaves the register unchanged.
- R11: An access that arrives while busy is high is ignored, and the current sequence goes on unchanged.
- R12: Accesses whose direction does not fit the opcode have no effect. These are a read under 01, a write under 10 and a read under 11.
- R13: After reset, busy, ta_o and bus_oe_o are low, ctl_o is 4'hF, cfg_ready_o is high, and both registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 selects the mode register, 1 selects the data register |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_ready_o | output | 1 | Register write is accepted this cycle |
| mode_o | output | 8 | Mode register value: opcode in bits [7:6], address in bits [5:0] |
| data_o | output | 32 | Data register value |
| acc_req_i | input | 1 | Access to the sequencer region, one-cycle pulse |
| acc_wr_i | input | 1 | Access direction, 1 for write |
| acc_burst_i | input | 1 | Burst access, used in normal mode |
| bmto_i | input | 1 | Bus-monitor timeout |
| ext_rdy_i | input | 1 | External ready for words with the wait bit set |
| ctl_o | output | 4 | Chip-select and strobe levels |
| amux_o | output | 1 | Address multiplex select |
| ta_o | output | 1 | Transfer acknowledge |
| bus_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Sequencer busy |

## Verification
All 64 RAM words are loaded with values computed from their addresses and then read back, which tests the store path, the fetch path and the address increment across the wrap. A run is started from every one of the 64 addresses. Since each group of eight words ends in a LAST word, every run length from one to eight is covered, and the step order is confirmed word by word. The four normal entries, a timeout partway through a read, and patterns containing a wait word and a loop word show where the entry points sit, how acknowledge differs between modes, and that steps are stretched only by the bit that asks for it.

// File: rtl/pattern_seq_pkg.sv
package pattern_seq_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [19:0] spare;
    logic [2:0]  rep;
    logic        wait_rdy;
    logic        last;
    logic        loop;
    logic        ta;
    logic        amux;
    logic [3:0]  ctl;
  } uword_t;

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_RDBK, ST_RUN, ST_EXC} st_e;

  localparam logic [1:0] OP_NORM = 2'b00;
  localparam logic [1:0] OP_LOAD = 2'b01;
  localparam logic [1:0] OP_RDBK = 2'b10;
  localparam logic [1:0] OP_RUN  = 2'b11;

  localparam uword_t IDLE_WORD = '{spare: '0, rep: '0, wait_rdy: 1'b0, last: 1'b0,
                                   loop: 1'b0, ta: 1'b0, amux: 1'b0, ctl: 4'hF};
endpackage

// File: rtl/pseq_ram.sv
module pseq_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pseq_engine.sv
module pseq_engine
  import pattern_seq_pkg::*;
#(
  parameter int            AW       = 6,
  parameter logic [AW-1:0] EXC_BASE = 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_seq_i,
  input  logic          go_load_i,
  input  logic          go_rdbk_i,
  input  logic [AW-1:0] seq_addr_i,
  input  logic          sw_i,
  input  logic          wr_i,
  input  logic          bmto_i,
  input  logic          ext_rdy_i,
  output logic [AW-1:0] raddr_o,
  input  uword_t        word_i,
  output uword_t        cur_o,
  output logic          sw_o,
  output logic          wr_o,
  output logic          busy_o,
  output logic          ld_done_o,
  output logic          rb_done_o
);
  st_e           st_q;
  logic [AW-1:0] pc_q, nxt_pc;
  uword_t        cur_q;
  logic [2:0]    cnt_q, cnt_ld;
  logic          sw_q, wr_q;
  logic          exc_go, stall_rdy;

  assign exc_go    = (st_q == ST_RUN) && bmto_i;
  assign stall_rdy = cur_q.wait_rdy && !ext_rdy_i;
  assign cnt_ld    = word_i.loop ? word_i.rep : 3'd0;

  always_comb begin
    if (st_q == ST_IDLE) nxt_pc = seq_addr_i;
    else if (exc_go)     nxt_pc = EXC_BASE;
    else                 nxt_pc = pc_q + 1'b1;
  end
  assign raddr_o = nxt_pc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      cur_q <= IDLE_WORD;
      cnt_q <= '0;
      sw_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (go_seq_i) begin
            st_q  <= ST_RUN;
            pc_q  <= nxt_pc;
            cur_q <= word_i;
            cnt_q <= cnt_ld;
            sw_q  <= sw_i;
            wr_q  <= wr_i;
          end else if (go_load_i) begin
            st_q <= ST_LOAD;
          end else if (go_rdbk_i) begin
            st_q <= ST_RDBK;
          end
        end
        ST_LOAD, ST_RDBK: st_q <= ST_IDLE;
        default: begin
          if (exc_go) begin
            st_q  <= ST_EXC;
            pc_q  <= nxt_pc;
            cur_q <= word_i;
            cnt_q <= cnt_ld;
          end else if (cnt_q != 3'd0) begin
            cnt_q <= cnt_q - 3'd1;
          end else if (stall_rdy) begin
            cnt_q <= '0;
          end else if (cur_q.last) begin
            st_q  <= ST_IDLE;
            cur_q <= IDLE_WORD;
            sw_q  <= 1'b0;
            wr_q  <= 1'b0;
          end else begin
            pc_q  <= nxt_pc;
            cur_q <= word_i;
            cnt_q <= cnt_ld;
          end
        end
      endcase
    end
  end

  assign cur_o     = cur_q;
  assign sw_o      = sw_q;
  assign wr_o      = wr_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign ld_done_o = (st_q == ST_LOAD);
  assign rb_done_o = (st_q == ST_RDBK);

  // R1
  dummy_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD || st_q == ST_RDBK) |=> st_q == ST_IDLE);
  // R4
  last_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN || st_q == ST_EXC) && cur_q.last && cnt_q == 3'd0 && !stall_rdy && !exc_go)
    |=> st_q == ST_IDLE);
  // R7
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN || st_q == ST_EXC) && cnt_q == 3'd0 && stall_rdy && !exc_go)
    |=> $stable(pc_q) && $stable(st_q));
  // R9
  exc_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && bmto_i) |=> (st_q == ST_EXC && pc_q == EXC_BASE));
endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
  import pattern_seq_pkg::*;
#(
  parameter int            AW       = 6,
  parameter logic [AW-1:0] RD1_BASE = 0,
  parameter logic [AW-1:0] RDB_BASE = 8,
  parameter logic [AW-1:0] WR1_BASE = 24,
  parameter logic [AW-1:0] WRB_BASE = 32,
  parameter logic [AW-1:0] EXC_BASE = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic              cfg_ready_o,
  output logic [AW+1:0]     mode_o,
  output logic [WORD_W-1:0] data_o,
  input  logic              acc_req_i,
  input  logic              acc_wr_i,
  input  logic              acc_burst_i,
  input  logic              bmto_i,
  input  logic              ext_rdy_i,
  output logic [3:0]        ctl_o,
  output logic              amux_o,
  output logic              ta_o,
  output logic              bus_oe_o,
  output logic              busy_o
);
  logic [1:0]        op_q;
  logic [AW-1:0]     mad_q, seq_addr, raddr_a;
  logic [WORD_W-1:0] mdr_q, rdata_a, rdata_b;
  logic              busy, ld_done, rb_done, sw, wr;
  logic              acc_ok, go_seq, go_load, go_rdbk;
  uword_t            cur;

  assign acc_ok  = acc_req_i && !busy;
  assign go_load = acc_ok && (op_q == OP_LOAD) && acc_wr_i;
  assign go_rdbk = acc_ok && (op_q == OP_RDBK) && !acc_wr_i;
  assign go_seq  = acc_ok && ((op_q == OP_RUN && acc_wr_i) || op_q == OP_NORM);

  always_comb begin
    unique case ({op_q == OP_RUN, acc_wr_i, acc_burst_i})
      3'b000:  seq_addr = RD1_BASE;
      3'b001:  seq_addr = RDB_BASE;
      3'b010:  seq_addr = WR1_BASE;
      3'b011:  seq_addr = WRB_BASE;
      default: seq_addr = mad_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_NORM;
      mad_q <= '0;
      mdr_q <= '0;
    end else begin
      if (cfg_we_i && !busy) begin
        if (cfg_sel_i) mdr_q <= cfg_wdata_i;
        else           {op_q, mad_q} <= cfg_wdata_i[AW+1:0];
      end
      if (ld_done || rb_done) mad_q <= mad_q + 1'b1;
      if (rb_done)            mdr_q <= rdata_b;
    end
  end

  pseq_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .clk_i     (clk_i),
    .we_i      (ld_done),
    .waddr_i   (mad_q),
    .wdata_i   (mdr_q),
    .raddr_a_i (raddr_a),
    .rdata_a_o (rdata_a),
    .raddr_b_i (mad_q),
    .rdata_b_o (rdata_b)
  );

  pseq_engine #(.AW(AW), .EXC_BASE(EXC_BASE)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_seq_i   (go_seq),
    .go_load_i  (go_load),
    .go_rdbk_i  (go_rdbk),
    .seq_addr_i (seq_addr),
    .sw_i       (op_q == OP_RUN),
    .wr_i       (acc_wr_i),
    .bmto_i     (bmto_i),
    .ext_rdy_i  (ext_rdy_i),
    .raddr_o    (raddr_a),
    .word_i     (uword_t'(rdata_a)),
    .cur_o      (cur),
    .sw_o       (sw),
    .wr_o       (wr),
    .busy_o     (busy),
    .ld_done_o  (ld_done),
    .rb_done_o  (rb_done)
  );

  assign cfg_ready_o = !busy;
  assign mode_o      = {op_q, mad_q};
  assign data_o      = mdr_q;
  assign ctl_o       = cur.ctl;
  assign amux_o      = cur.amux;
  assign ta_o        = cur.ta && !sw;
  assign bus_oe_o    = wr;
  assign busy_o      = busy;

  // R5
  sw_ta_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw |-> !ta_o);
  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !rb_done) |=> $stable(mdr_q));
  // R13
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ctl_o == 4'hF && !ta_o && !bus_oe_o));
endmodule

// File: tb/pattern_seq_bench.sv
module pattern_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        cfg_ready;
  logic [7:0]  mode;
  logic [31:0] data;
  logic        acc_req, acc_wr, acc_burst, bmto, ext_rdy;
  logic [3:0]  ctl;
  logic        amux, ta, bus_oe, busy;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  pattern_seq u_pattern_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_ready_o(cfg_ready), .mode_o(mode), .data_o(data),
    .acc_req_i(acc_req), .acc_wr_i(acc_wr), .acc_burst_i(acc_burst), .bmto_i(bmto),
    .ext_rdy_i(ext_rdy), .ctl_o(ctl), .amux_o(amux), .ta_o(ta), .bus_oe_o(bus_oe),
    .busy_o(busy)
  );

  function automatic logic [31:0] fw(int i, bit wt, bit lp, int rep);
    return {14'(i * 37 + 5), 6'(i), 3'(rep), wt, (i % 8 == 7), lp, 1'b1, 1'(i % 2), 4'(i % 16)};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cfg(bit sel, logic [31:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(bit wr, bit burst);
    acc_wr = wr; acc_burst = burst; acc_req = 1'b1;
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  // checks the current and following steps from address 'first' to its LAST word
  task automatic seq(int first, bit exp_ta, bit exp_oe, string r);
    for (int k = 0; k < 8; k++) begin
      int a = first + k;
      chk(r, {ctl, amux, ta, bus_oe, busy}, {4'(a % 16), 1'(a % 2), exp_ta, exp_oe, 1'b1});
      @(negedge clk);
      if (a % 8 == 7) begin
        chk(r, {ctl, busy}, {4'hF, 1'b0});
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_req = 0; acc_wr = 0; acc_burst = 0; bmto = 0; ext_rdy = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13
    chk("R13", {busy, ta, bus_oe, ctl, cfg_ready}, {3'b000, 4'hF, 1'b1});
    chk("R13", {24'd0, mode}, 32'd0);
    chk("R13", data, 32'd0);

    // R1 load sweep, R12 read under 01
    cfg(0, 32'h40);
    acc(0, 0);
    chk("R12", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R12", {24'd0, mode}, 32'h40);
    for (int i = 0; i < 64; i++) begin
      cfg(1, fw(i, 0, 0, 0));
      acc(1, 0);
      chk("R1", {31'd0, busy}, 32'd1);
      @(negedge clk);
      chk("R1", {busy, 23'd0, mode}, {1'b0, 23'd0, 2'b01, 6'((i + 1) % 64)});
    end

    // R2 readback sweep, R12 write under 10
    cfg(0, 32'h80);
    acc(1, 0);
    chk("R12", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R12", {24'd0, mode}, 32'h80);
    for (int i = 0; i < 64; i++) begin
      acc(0, 0);
      @(negedge clk);
      chk("R2", data, fw(i, 0, 0, 0));
      chk("R2", {24'd0, mode}, {24'd0, 2'b10, 6'((i + 1) % 64)});
    end

    // R3/R4/R5 runs from every start, R12 read under 11
    cfg(0, 32'hC0);
    acc(0, 0);
    chk("R12", {31'd0, busy}, 32'd0);
    @(negedge clk);
    for (int s = 0; s < 64; s++) begin
      cfg(0, 32'hC0 | 32'(s));
      acc(1, 0);
      seq(s, 1'b0, 1'b1, "R3_R4_R5");
    end

    // R6 normal entries, R5 ack honoured
    cfg(0, 32'h00);
    acc(0, 0); seq(0, 1'b1, 1'b0, "R6_rd1");
    acc(0, 1); seq(8, 1'b1, 1'b0, "R6_rdb");
    acc(1, 0); seq(24, 1'b1, 1'b1, "R6_wr1");
    acc(1, 1); seq(32, 1'b1, 1'b1, "R6_wrb");

    // R9 timeout during normal read
    acc(0, 0);
    chk("R9", {28'd0, ctl}, 32'h0);
    @(negedge clk);
    chk("R9", {28'd0, ctl}, 32'h1);
    bmto = 1'b1;
    @(negedge clk);
    chk("R9", {28'd0, ctl}, 32'hC);
    @(negedge clk);
    bmto = 1'b0;
    seq(61, 1'b1, 1'b0, "R9");

    // R11 access during run ignored
    cfg(0, 32'hC0 | 32'd16);
    acc(1, 0);
    chk("R11", {28'd0, ctl}, 32'h0);
    acc(1, 0);
    seq(17, 1'b0, 1'b1, "R11");

    // R10 register write while busy dropped
    cfg(0, 32'hC0 | 32'd16);
    acc(1, 0);
    cfg_sel = 1'b1; cfg_wdata = 32'hDEADBEEF; cfg_we = 1'b1;
    chk("R10", {31'd0, cfg_ready}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10", data, fw(63, 0, 0, 0));
    while (busy) @(negedge clk);
    chk("R10", data, fw(63, 0, 0, 0));

    // rewrite word 41 with wait, word 50 with loop
    cfg(1, fw(41, 1, 0, 0)); cfg(0, 32'h40 | 32'd41); acc(1, 0); @(negedge clk);
    cfg(1, fw(50, 0, 1, 2)); cfg(0, 32'h40 | 32'd50); acc(1, 0); @(negedge clk);

    // R7 wait bit
    ext_rdy = 1'b0;
    cfg(0, 32'hC0 | 32'd40);
    acc(1, 0);
    chk("R7", {28'd0, ctl}, 32'h8);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7", {28'd0, ctl}, 32'h9);
    end
    ext_rdy = 1'b1;
    @(negedge clk);
    seq(42, 1'b0, 1'b1, "R7");

    // R8 loop bit, repeat 2 -> three cycles
    cfg(0, 32'hC0 | 32'd48);
    acc(1, 0);
    chk("R8", {28'd0, ctl}, 32'h0);
    @(negedge clk);
    chk("R8", {28'd0, ctl}, 32'h1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", {28'd0, ctl}, 32'h2);
    end
    @(negedge clk);
    seq(51, 1'b0, 1'b1, "R8");

    // R2 readback of rewritten word
    cfg(0, 32'h80 | 32'd41);
    acc(0, 0);
    @(negedge clk);
    chk("R2", data, fw(41, 1, 0, 0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule